// File: doc/BRIEF.md
# CAN Controller Interrupt Flag Register

This block gathers single-cycle event strobes from the receive path, the transmit path and the bus-state monitor of a small CAN controller with two receive buffers, and turns them into sticky flags that a CPU reads through an 8-bit register port. Software clears flags by writing 0 to their bit positions. A 1 in the write data leaves the matching flag alone, so a single mask write clears a chosen set of flags without a read-modify-write sequence.

Each receive flag has a second clear path. A strobe from the control logic of its buffer clears the flag when that buffer's ready bit is cleared. Bit 0 summarises the three error flags, and only hardware maintains it. An interrupt request output combines every flag with its own enable input. When a hardware event and a software clear hit the same flag in the same cycle, the event wins and is not lost.

Top module: `can_isr`

## Requirements
- R1: After reset the register reads 8'h00 and `irq` is 0.
- R2: Bit positions: bit 6 receive buffer 2, bit 5 receive buffer 1, bit 4 transmit done, bit 3 status change, bit 2 overrun, bit 1 transmit error, bit 0 error pending. Bit 7 always reads 0, and a write cannot set it.
- R3: A write (`sel` and `wr_en` high on a clock edge) with 0 in bit position 6..1 clears that flag. A 1 leaves the flag unchanged. When `sel` or `wr_en` is low, the write data has no effect.
- R4: A pulse on `rx1_ok` sets bit 5 and a pulse on `rx2_ok` sets bit 6. Each flag holds until it is cleared.
- R5: A pulse on `rdy1_clr` clears bit 5 and a pulse on `rdy2_clr` clears bit 6. Neither strobe touches any other bit.
- R6: A pulse on `tx_done` sets bit 4 and a pulse on `tx_err` sets bit 1.
- R7: A pulse on `overrun` sets bit 2, which holds until it is cleared.
- R8: Bit 3 is set by a pulse on `dom_standby` or on `epass_chg`. It is also set by a pulse on `rx_err`, but only while `err_stat_ie` is 1. A pulse on `rx_err` while `err_stat_ie` is 0 has no effect.
- R9: Bit 0 reads 1 exactly when at least one of bits 3, 2 and 1 is 1, and it reads 0 once all three are clear. Writes to bit 0 are ignored.
- R10: When a set event and a clear (by write or by ready strobe) of the same flag fall in the same cycle, the flag ends up set.
- R11: `irq` is 1 exactly when some register bit i (0..6) is 1 and `irq_en[i]` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Register select |
| wr_en | input | 1 | Write enable, qualified by `sel` |
| wdata | input | 8 | Write data; a 0 clears the flag in that position |
| rdata | output | 8 | Current register contents |
| rx1_ok | input | 1 | Error-free message stored in buffer 1 |
| rx2_ok | input | 1 | Error-free message stored in buffer 2 |
| tx_done | input | 1 | Highest-priority queued message sent |
| tx_err | input | 1 | Transmission of that message failed |
| overrun | input | 1 | Message dropped, no free receive buffer |
| dom_standby | input | 1 | Dominant bit seen while in standby |
| epass_chg | input | 1 | Error-passive status changed while running |
| rx_err | input | 1 | Receive error detected |
| err_stat_ie | input | 1 | Lets receive errors set the status-change flag |
| rdy1_clr | input | 1 | Ready bit of buffer 1 cleared |
| rdy2_clr | input | 1 | Ready bit of buffer 2 cleared |
| irq_en | input | 7 | Per-bit interrupt enables for bits 6..0 |
| irq | output | 1 | Interrupt request |

## Verification
The block has no parameters, so the bench builds its one fixed 8-bit layout. That single build covers every flag position, both receive clear paths, all three status-change sources with the receive-error enable on and off, and the summary bit as the error flags come and go. It also drives events and clears into the same cycle to show that the event is kept.

// File: rtl/can_isr.sv
module can_isr (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       rx1_ok,
  input  logic       rx2_ok,
  input  logic       tx_done,
  input  logic       tx_err,
  input  logic       overrun,
  input  logic       dom_standby,
  input  logic       epass_chg,
  input  logic       rx_err,
  input  logic       err_stat_ie,
  input  logic       rdy1_clr,
  input  logic       rdy2_clr,
  input  logic [6:0] irq_en,
  output logic       irq
);

  // flag[5]=rx buf2, [4]=rx buf1, [3]=tx done, [2]=status change, [1]=overrun, [0]=tx error
  logic [5:0] flag;
  logic [5:0] set_v, clr_v;
  logic       pend;
  logic       sc_set;

  assign sc_set = dom_standby | epass_chg | (rx_err & err_stat_ie);
  assign set_v  = {rx2_ok, rx1_ok, tx_done, sc_set, overrun, tx_err};
  assign clr_v  = ((sel & wr_en) ? ~wdata[6:1] : 6'b0) | {rdy2_clr, rdy1_clr, 4'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) flag <= '0;
    else        flag <= (flag & ~clr_v) | set_v;
  end

  assign pend  = |flag[2:0];
  assign rdata = {1'b0, flag, pend};
  assign irq   = |(rdata[6:0] & irq_en);

endmodule

module can_isr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sel,
  input logic       wr_en,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       rx1_ok,
  input logic       rx2_ok,
  input logic       tx_done,
  input logic       overrun,
  input logic       rdy2_clr,
  input logic [6:0] irq_en,
  input logic       irq
);

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n) rdata[7] == 1'b0); // R2
  AST_PEND_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n) rdata[0] == (|rdata[3:1])); // R9
  AST_RX1_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n) rx1_ok |=> rdata[5]); // R10
  AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (sel && wr_en && !wdata[4] && !tx_done) |=> !rdata[4]); // R3
  AST_RDY2_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (rdy2_clr && !rx2_ok) |=> !rdata[6]); // R5
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (!overrun && !(sel && wr_en && !wdata[2])) |=> $stable(rdata[2])); // R7
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n) irq == (|(rdata[6:0] & irq_en))); // R11

endmodule

bind can_isr can_isr_chk u_chk (.*);

// File: tb/can_isr_test.sv
module can_isr_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       sel = 0, wr_en = 0;
  logic [7:0] wdata = 8'hFF;
  logic [7:0] rdata;
  logic       rx1_ok = 0, rx2_ok = 0, tx_done = 0, tx_err = 0, overrun = 0;
  logic       dom_standby = 0, epass_chg = 0, rx_err = 0, err_stat_ie = 0;
  logic       rdy1_clr = 0, rdy2_clr = 0;
  logic [6:0] irq_en = 0;
  logic       irq;
  int         n_run = 0, n_fail = 0;
  bit         done = 0;

  can_isr uut (.*);

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    sel = 0; wr_en = 0; wdata = 8'hFF;
    rx1_ok = 0; rx2_ok = 0; tx_done = 0; tx_err = 0; overrun = 0;
    dom_standby = 0; epass_chg = 0; rx_err = 0; rdy1_clr = 0; rdy2_clr = 0;
  endtask

  task automatic step();
    @(negedge clk); idle();
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); sel = 1; wr_en = 1; wdata = d;
    step();
  endtask

  task automatic t_reset();
    chk("R1 reset rdata", rdata, 8'h00);
    chk("R1 reset irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_rx();
    @(negedge clk); rx1_ok = 1; step();
    chk("R4 rx1 sets bit5", rdata, 8'h20);
    @(negedge clk); rx2_ok = 1; step();
    chk("R4 rx2 sets bit6", rdata, 8'h60);
    @(negedge clk); sel = 0; wr_en = 1; wdata = 8'h00; step();
    chk("R3 write without sel ignored", rdata, 8'h60);
    @(negedge clk); sel = 1; wr_en = 0; wdata = 8'h00; step();
    chk("R3 select without write ignored", rdata, 8'h60);
    wr(8'hDF);
    chk("R3 mask write clears bit5 only", rdata, 8'h40);
    @(negedge clk); rdy1_clr = 1; rx2_ok = 1; step();
    chk("R5 rdy1 strobe leaves bit6", rdata, 8'h40);
    @(negedge clk); rdy2_clr = 1; step();
    chk("R5 rdy2 strobe clears bit6", rdata, 8'h00);
  endtask

  task automatic t_tx();
    @(negedge clk); tx_done = 1; step();
    chk("R6 tx done bit4", rdata, 8'h10);
    @(negedge clk); tx_err = 1; step();
    chk("R6 R9 tx error bit1 and pending", rdata, 8'h13);
    wr(8'hFF);
    chk("R3 ones leave flags", rdata, 8'h13);
    wr(8'hFD);
    chk("R9 pending drops with last error flag", rdata, 8'h10);
    wr(8'hEF);
    chk("R3 clear tx done", rdata, 8'h00);
  endtask

  task automatic t_ovr();
    @(negedge clk); overrun = 1; step();
    chk("R7 overrun bit2", rdata, 8'h05);
    step();
    chk("R7 overrun holds", rdata, 8'h05);
    wr(8'hFE);
    chk("R9 write to pending ignored", rdata, 8'h05);
    wr(8'hFB);
    chk("R7 overrun cleared", rdata, 8'h00);
  endtask

  task automatic t_sc();
    @(negedge clk); dom_standby = 1; step();
    chk("R8 standby dominant sets bit3", rdata, 8'h09);
    wr(8'hF7);
    @(negedge clk); epass_chg = 1; step();
    chk("R8 error-passive change sets bit3", rdata, 8'h09);
    wr(8'hF7);
    err_stat_ie = 0;
    @(negedge clk); rx_err = 1; step();
    chk("R8 rx error masked", rdata, 8'h00);
    err_stat_ie = 1;
    @(negedge clk); rx_err = 1; step();
    chk("R8 rx error enabled sets bit3", rdata, 8'h09);
    err_stat_ie = 0;
    wr(8'hF7);
    chk("R9 pending clear after bit3", rdata, 8'h00);
  endtask

  task automatic t_race();
    @(negedge clk); rx1_ok = 1; sel = 1; wr_en = 1; wdata = 8'h00; step();
    chk("R10 set beats write clear", rdata, 8'h20);
    @(negedge clk); rx1_ok = 1; rdy1_clr = 1; step();
    chk("R10 set beats ready clear", rdata, 8'h20);
    @(negedge clk); overrun = 1; sel = 1; wr_en = 1; wdata = 8'h00; step();
    chk("R10 overrun survives clear-all", rdata, 8'h05);
    wr(8'h00);
    chk("R3 clear all", rdata, 8'h00);
  endtask

  task automatic t_layout();
    @(negedge clk);
    rx1_ok = 1; rx2_ok = 1; tx_done = 1; tx_err = 1; overrun = 1; dom_standby = 1;
    step();
    chk("R2 all flags, bit7 zero", rdata, 8'h7F);
    wr(8'hFF);
    chk("R2 write of bit7 ignored", rdata, 8'h7F);
    wr(8'h00);
    chk("R2 all cleared", rdata, 8'h00);
  endtask

  task automatic t_irq();
    @(negedge clk); rx1_ok = 1; tx_done = 1; step();
    irq_en = 7'h01; #1;
    chk("R11 enable on clear bit", {7'b0, irq}, 8'h00);
    irq_en = 7'h10; #1;
    chk("R11 enable on set bit", {7'b0, irq}, 8'h01);
    irq_en = 7'h4F; #1;
    chk("R11 other enables only", {7'b0, irq}, 8'h00);
    @(negedge clk); tx_err = 1; step();
    chk("R11 pending bit via enable 0", {7'b0, irq}, 8'h01);
    wr(8'h00);
    irq_en = 7'h7F; #1;
    chk("R11 no flags no irq", {7'b0, irq}, 8'h00);
    irq_en = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_rx();
    t_tx();
    t_ovr();
    t_sc();
    t_race();
    t_layout();
    t_irq();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule